// File: doc/BRIEF.md
# Dual-Mode Complex Multiplier

This block multiplies two signed complex numbers, (a + jb) times (c + jd). It returns the real part ac − bd and the imaginary part ad + bc. Four signed multipliers work on the fixed operand pairings a·c, b·d, a·d and b·c. A subtractor combines the first two products into the real result. An adder combines the last two into the imaginary result.

A per-transaction mode bit picks how the same datapath is used. In wide mode it performs one 18-bit complex multiply. In split mode each 18-bit operand port carries two independent 9-bit lanes, and the block performs two separate complex multiplies side by side, with no carry or sign passing between the lanes. An input strobe qualifies each operand set. The result and a matching valid flag come out a fixed number of cycles later.

Top module: `dual_cmul`

## Requirements
- R1: With `half_mode`=0, `out_re` equals a·c − b·d, where a, b, c and d are the 18-bit signed values on `op_a`, `op_b`, `op_c` and `op_d`. The 37-bit signed result is sign-extended to the 38-bit port.
- R2: With `half_mode`=0, `out_im` equals a·d + b·c, sign-extended from 37 to 38 bits in the same way.
- R3: With `half_mode`=1, each input port holds lane 0 in bits [8:0] and lane 1 in bits [17:9], each a 9-bit signed value. `out_re` bits [18:0] hold lane 0's 19-bit real result, and bits [37:19] hold lane 1's.
- R4: With `half_mode`=1, `out_im` bits [18:0] and [37:19] hold the 19-bit imaginary results of lane 0 and lane 1.
- R5: In split mode, the operand values of one lane, including the most negative ones, have no effect on the other lane's results.
- R6: An operand set sampled with `in_valid`=1 on rising edge k gives `out_valid`=1 from just after edge k+2 until edge k+3. `out_valid` is never raised without a matching input, and every accepted input yields exactly one result.
- R7: The mode is captured with each operand set. Back-to-back inputs that alternate modes are each computed in their own mode.
- R8: While `out_valid` is 0, `out_re` and `out_im` keep the last result they carried.
- R9: While `rst_n` is low, `out_valid`, `out_re` and `out_im` are 0. Inputs still in flight when reset is asserted never produce a result.
- R10: The most negative operands give exact results: wide mode all −131072 gives re=0 and im=2^35; split lane all −256 gives re=0 and im=131072.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Operand set on the inputs is taken this cycle |
| half_mode | input | 1 | 0: one 18-bit multiply, 1: two 9-bit lanes |
| op_a | input | 18 | Real part of first operand |
| op_b | input | 18 | Imaginary part of first operand |
| op_c | input | 18 | Real part of second operand |
| op_d | input | 18 | Imaginary part of second operand |
| out_valid | output | 1 | Result on `out_re`/`out_im` is new this cycle |
| out_re | output | 38 | Real result (one wide value or two packed lanes) |
| out_im | output | 38 | Imaginary result (one wide value or two packed lanes) |

## Verification
The bound checker keeps a shadow of the inputs. On every cycle it checks the three-stage valid timing, the arithmetic of each emerging result in whichever mode it was launched, the holding of the outputs between results and the cleared outputs right after reset. Some behaviour only the bench's scenarios can show. These are lane isolation under extreme operands, modes alternating back to back, the exact most-negative corner values, and a reset that lands while data is in flight.

// File: rtl/cmul_pkg.sv
package cmul_pkg;
  typedef enum logic {
    MODE_WIDE  = 1'b0,
    MODE_SPLIT = 1'b1
  } cmul_mode_e;
endpackage

// File: rtl/cmul_in_reg.sv
module cmul_in_reg
  import cmul_pkg::*;
#(
  parameter int W = 18
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  cmul_mode_e mode_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  input  logic [W-1:0] d_i,
  output cmul_mode_e mode_q,
  output logic [W-1:0] a_q,
  output logic [W-1:0] b_q,
  output logic [W-1:0] c_q,
  output logic [W-1:0] d_q
);
  cmul_mode_e   mode_d;
  logic [W-1:0] a_d, b_d, c_d, d_d;

  always_comb begin
    mode_d = mode_q;
    a_d = a_q;
    b_d = b_q;
    c_d = c_q;
    d_d = d_q;
    if (en) begin
      mode_d = mode_i;
      a_d = a_i;
      b_d = b_i;
      c_d = c_i;
      d_d = d_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_WIDE;
      a_q <= '0;
      b_q <= '0;
      c_q <= '0;
      d_q <= '0;
    end else begin
      mode_q <= mode_d;
      a_q <= a_d;
      b_q <= b_d;
      c_q <= c_d;
      d_q <= d_d;
    end
  end
endmodule

// File: rtl/cmul_prod.sv
module cmul_prod
  import cmul_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  cmul_mode_e   mode,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [2*W-1:0] p_q
);
  localparam int H = W / 2;

  logic signed [2*W-1:0] wide_p;
  logic [2*W-1:0] split_p;
  logic [2*W-1:0] p_d;

  assign wide_p = $signed(x) * $signed(y);

  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic signed [H-1:0]   xl, yl;
    logic signed [2*H-1:0] pl;
    assign xl = x[l*H +: H];
    assign yl = y[l*H +: H];
    assign pl = xl * yl;
    assign split_p[l*2*H +: 2*H] = pl;
  end

  always_comb begin
    p_d = p_q;
    if (en) begin
      p_d = (mode == MODE_SPLIT) ? split_p : wide_p;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) p_q <= '0;
    else        p_q <= p_d;
  end
endmodule

// File: rtl/cmul_combine.sv
module cmul_combine
  import cmul_pkg::*;
#(
  parameter int W   = 18,
  parameter bit SUB = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  cmul_mode_e     mode,
  input  logic [2*W-1:0] p,
  input  logic [2*W-1:0] q,
  output logic [2*W+1:0] r_q
);
  localparam int H  = W / 2;
  localparam int LR = 2 * H + 1;

  logic [2*W:0]   wide_ext_p, wide_ext_q, wide_r;
  logic [2*W+1:0] split_r;
  logic [2*W+1:0] r_d;

  assign wide_ext_p = {p[2*W-1], p};
  assign wide_ext_q = {q[2*W-1], q};

  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic [2*H-1:0] pl, ql;
    logic [LR-1:0]  ep, eq, rl;
    assign pl = p[l*2*H +: 2*H];
    assign ql = q[l*2*H +: 2*H];
    assign ep = {pl[2*H-1], pl};
    assign eq = {ql[2*H-1], ql};
    if (SUB) begin : g_sub
      assign rl = ep - eq;
    end else begin : g_add
      assign rl = ep + eq;
    end
    assign split_r[l*LR +: LR] = rl;
  end

  if (SUB) begin : g_wsub
    assign wide_r = wide_ext_p - wide_ext_q;
  end else begin : g_wadd
    assign wide_r = wide_ext_p + wide_ext_q;
  end

  always_comb begin
    r_d = r_q;
    if (en) begin
      r_d = (mode == MODE_SPLIT) ? split_r : {wide_r[2*W], wide_r};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) r_q <= '0;
    else        r_q <= r_d;
  end
endmodule

// File: rtl/dual_cmul.sv
module dual_cmul
  import cmul_pkg::*;
#(
  parameter int W = 18
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           half_mode,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  input  logic [W-1:0]   op_c,
  input  logic [W-1:0]   op_d,
  output logic           out_valid,
  output logic [2*W+1:0] out_re,
  output logic [2*W+1:0] out_im
);
  localparam int NMUL = 4;

  cmul_mode_e   mode1, mode2, mode2_d;
  logic         v1, v2, v3;
  logic         v1_d, v2_d, v3_d;
  logic [W-1:0] a1, b1, c1, d1;
  logic [W-1:0] mx [NMUL];
  logic [W-1:0] my [NMUL];
  logic [2*W-1:0] prod [NMUL];

  cmul_in_reg #(.W(W)) u_in (
    .clk(clk), .rst_n(rst_n), .en(in_valid),
    .mode_i(cmul_mode_e'(half_mode)),
    .a_i(op_a), .b_i(op_b), .c_i(op_c), .d_i(op_d),
    .mode_q(mode1), .a_q(a1), .b_q(b1), .c_q(c1), .d_q(d1)
  );

  // fixed pairing: 0 a*c, 1 b*d, 2 a*d, 3 b*c
  always_comb begin
    mx[0] = a1; my[0] = c1;
    mx[1] = b1; my[1] = d1;
    mx[2] = a1; my[2] = d1;
    mx[3] = b1; my[3] = c1;
  end

  for (genvar i = 0; i < NMUL; i++) begin : g_mul
    cmul_prod #(.W(W)) u_prod (
      .clk(clk), .rst_n(rst_n), .en(v1), .mode(mode1),
      .x(mx[i]), .y(my[i]), .p_q(prod[i])
    );
  end

  cmul_combine #(.W(W), .SUB(1'b1)) u_real (
    .clk(clk), .rst_n(rst_n), .en(v2), .mode(mode2),
    .p(prod[0]), .q(prod[1]), .r_q(out_re)
  );

  cmul_combine #(.W(W), .SUB(1'b0)) u_imag (
    .clk(clk), .rst_n(rst_n), .en(v2), .mode(mode2),
    .p(prod[2]), .q(prod[3]), .r_q(out_im)
  );

  always_comb begin
    v1_d = in_valid;
    v2_d = v1;
    v3_d = v2;
    mode2_d = v1 ? mode1 : mode2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
      mode2 <= MODE_WIDE;
    end else begin
      v1 <= v1_d;
      v2 <= v2_d;
      v3 <= v3_d;
      mode2 <= mode2_d;
    end
  end

  assign out_valid = v3;
endmodule

// File: rtl/dual_cmul_checker.sv
module dual_cmul_checker #(
  parameter int W = 18
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           half_mode,
  input logic [W-1:0]   op_a,
  input logic [W-1:0]   op_b,
  input logic [W-1:0]   op_c,
  input logic [W-1:0]   op_d,
  input logic           out_valid,
  input logic [2*W+1:0] out_re,
  input logic [2*W+1:0] out_im
);
  localparam int H  = W / 2;
  localparam int OW = 2 * W + 2;
  localparam int LR = 2 * H + 1;
  localparam int D  = 3;

  logic [1:0]   since_rst;
  logic         sv [D];
  logic         sm [D];
  logic [W-1:0] sa [D];
  logic [W-1:0] sb [D];
  logic [W-1:0] sc [D];
  logic [W-1:0] sd [D];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= '0;
      for (int i = 0; i < D; i++) begin
        sv[i] <= 1'b0; sm[i] <= 1'b0;
        sa[i] <= '0; sb[i] <= '0; sc[i] <= '0; sd[i] <= '0;
      end
    end else begin
      if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
      sv[0] <= in_valid; sm[0] <= half_mode;
      sa[0] <= op_a; sb[0] <= op_b; sc[0] <= op_c; sd[0] <= op_d;
      for (int i = 1; i < D; i++) begin
        sv[i] <= sv[i-1]; sm[i] <= sm[i-1];
        sa[i] <= sa[i-1]; sb[i] <= sb[i-1]; sc[i] <= sc[i-1]; sd[i] <= sd[i-1];
      end
    end
  end

  function automatic logic [OW-1:0] expect_val(input logic split, input logic [W-1:0] a,
      input logic [W-1:0] b, input logic [W-1:0] c, input logic [W-1:0] d, input logic im);
    logic [OW-1:0] r;
    longint s;
    r = '0;
    if (!split) begin
      s = im ? longint'($signed(a)) * longint'($signed(d)) + longint'($signed(b)) * longint'($signed(c))
             : longint'($signed(a)) * longint'($signed(c)) - longint'($signed(b)) * longint'($signed(d));
      r = s[OW-1:0];
    end else begin
      for (int l = 0; l < 2; l++) begin
        logic signed [H-1:0] ta, tb, tc, td;
        ta = a[l*H +: H]; tb = b[l*H +: H]; tc = c[l*H +: H]; td = d[l*H +: H];
        s = im ? longint'(ta) * longint'(td) + longint'(tb) * longint'(tc)
               : longint'(ta) * longint'(tc) - longint'(tb) * longint'(td);
        r[l*LR +: LR] = s[LR-1:0];
      end
    end
    return r;
  endfunction

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == sv[D-1]); // R6

  AST_REAL_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_re == expect_val(sm[D-1], sa[D-1], sb[D-1], sc[D-1], sd[D-1], 1'b0)); // R1 R3

  AST_IMAG_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_im == expect_val(sm[D-1], sa[D-1], sb[D-1], sc[D-1], sd[D-1], 1'b1)); // R2 R4

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2 && !out_valid) |-> ($stable(out_re) && $stable(out_im))); // R8

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd0) |-> (!out_valid && out_re == '0 && out_im == '0)); // R9
endmodule

bind dual_cmul dual_cmul_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .half_mode(half_mode),
  .op_a(op_a), .op_b(op_b), .op_c(op_c), .op_d(op_d),
  .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
);

// File: tb/sim_dual_cmul.sv
`timescale 1ns/1ps
module sim_dual_cmul;
  localparam int W  = 18;
  localparam int H  = W / 2;
  localparam int OW = 2 * W + 2;
  localparam int LR = 2 * H + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic half_mode = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0, op_c = '0, op_d = '0;
  logic out_valid;
  logic [OW-1:0] out_re, out_im;

  always #2.5 clk = ~clk;

  dual_cmul #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .half_mode(half_mode),
    .op_a(op_a), .op_b(op_b), .op_c(op_c), .op_d(op_d),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
  );

  typedef struct {
    logic [OW-1:0] re;
    logic [OW-1:0] im;
    int            due;
    string         req;
  } item_t;

  item_t exp_q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [OW-1:0] last_re = '0, last_im = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [OW-1:0] act, input logic [OW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [OW-1:0] ref_out(input bit split, input logic [W-1:0] a, input logic [W-1:0] b,
      input logic [W-1:0] c, input logic [W-1:0] d, input bit im);
    logic [OW-1:0] r;
    longint va, vb, vc, vd, s;
    r = '0;
    if (!split) begin
      va = longint'($signed(a)); vb = longint'($signed(b));
      vc = longint'($signed(c)); vd = longint'($signed(d));
      s = im ? va * vd + vb * vc : va * vc - vb * vd;
      r = s[OW-1:0];
    end else begin
      for (int l = 0; l < 2; l++) begin
        logic signed [H-1:0] ta, tb, tc, td;
        ta = a[l*H +: H]; tb = b[l*H +: H]; tc = c[l*H +: H]; td = d[l*H +: H];
        va = longint'(ta); vb = longint'(tb); vc = longint'(tc); vd = longint'(td);
        s = im ? va * vd + vb * vc : va * vc - vb * vd;
        r[l*LR +: LR] = s[LR-1:0];
      end
    end
    return r;
  endfunction

  // driver: one operand set per call, expected result pushed to the scoreboard
  task automatic send(input bit split, input logic [W-1:0] a, input logic [W-1:0] b,
      input logic [W-1:0] c, input logic [W-1:0] d, input string req);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1; half_mode = split;
    op_a = a; op_b = b; op_c = c; op_d = d;
    it.re = ref_out(split, a, b, c, d, 1'b0);
    it.im = ref_out(split, a, b, c, d, 1'b1);
    it.due = cyc + 3;
    it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      op_a = W'($urandom); op_b = W'($urandom); op_c = W'($urandom); op_d = W'($urandom);
    end
  endtask

  // monitor: pops and compares each result as it appears
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 (result without input)", {{(OW-1){1'b0}}, out_valid}, '0);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        chk(out_re == e.re, {e.req, " real"}, out_re, e.re);
        chk(out_im == e.im, {e.req, " imag"}, out_im, e.im);
        chk(cyc == e.due, "R6 latency", OW'(cyc), OW'(e.due));
      end
      last_re = out_re;
      last_im = out_im;
    end
  end

  function automatic logic [W-1:0] pack2(input int lo, input int hi);
    logic [H-1:0] l0, l1;
    l0 = H'(lo); l1 = H'(hi);
    return {l1, l0};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R9 reset valid", {{(OW-1){1'b0}}, out_valid}, '0);
    chk(out_re == '0 && out_im == '0, "R9 reset data", out_re | out_im, '0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R1 R2: simple and signed wide operands
    send(1'b0, 18'd3, 18'd4, 18'd5, -18'sd2, "R1/R2 small");
    send(1'b0, -18'sd1000, 18'd777, 18'd12345, -18'sd54321, "R1/R2 mixed");
    send(1'b0, 18'h1FFFF, 18'h1FFFF, 18'h1FFFF, 18'h1FFFF, "R1/R2 max positive");
    // R10: most negative wide
    send(1'b0, 18'h20000, 18'h20000, 18'h20000, 18'h20000, "R10 wide corner");
    idle(4);
    // R8: outputs hold after the stream drains
    chk(out_re == last_re, "R8 hold real", out_re, last_re);
    chk(out_im == last_im, "R8 hold imag", out_im, last_im);

    // R3 R4: split lanes
    send(1'b1, pack2(3, -7), pack2(4, 2), pack2(5, 9), pack2(-2, -11), "R3/R4 lanes");
    // R10 + R5: lane 0 at most negative, lane 1 small
    send(1'b1, pack2(-256, 1), pack2(-256, 2), pack2(-256, 3), pack2(-256, 4), "R5/R10 lane0 extreme");
    send(1'b1, pack2(1, -256), pack2(2, -256), pack2(3, -256), pack2(4, -256), "R5/R10 lane1 extreme");
    send(1'b1, pack2(255, -1), pack2(-256, -1), pack2(255, 0), pack2(255, -256), "R5 sign isolation");
    // R7: alternating modes back to back
    send(1'b0, 18'h12345, 18'h2ABCD, 18'h00F0F, 18'h3F00F, "R7 wide in stream");
    send(1'b1, 18'h12345, 18'h2ABCD, 18'h00F0F, 18'h3F00F, "R7 split in stream");
    send(1'b0, 18'h3FFFF, 18'h00001, 18'h20000, 18'h1FFFF, "R7 wide again");
    send(1'b1, 18'h3FFFF, 18'h00001, 18'h20000, 18'h1FFFF, "R7 split again");
    idle(1);
    send(1'b1, pack2(-100, 50), pack2(7, -8), pack2(33, 44), pack2(-55, 66), "R3/R4 after gap");
    idle(5);
    chk(out_re == last_re, "R8 hold real 2", out_re, last_re);

    // random mix of modes and gaps
    for (int i = 0; i < 60; i++) begin
      send(1'($urandom), W'($urandom), W'($urandom), W'($urandom), W'($urandom), "R1/R2/R3/R4 random");
      if ($urandom % 4 == 0) idle(1 + $urandom % 3);
    end
    idle(6);
    chk(exp_q.size() == 0, "R6 all results produced", OW'(exp_q.size()), '0);

    // R9: reset while data is in flight
    send(1'b0, 18'd100, 18'd200, 18'd300, 18'd400, "R9 in flight");
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    exp_q.delete();
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 mid-run valid", {{(OW-1){1'b0}}, out_valid}, '0);
    chk(out_re == '0 && out_im == '0, "R9 mid-run data", out_re | out_im, '0);
    @(negedge clk);
    rst_n = 1'b1;
    last_re = '0; last_im = '0;
    idle(5);
    chk(out_re == '0, "R9 no late result", out_re, '0);
    send(1'b1, pack2(2, 3), pack2(4, 5), pack2(6, 7), pack2(8, 9), "R3/R4 after reset");
    idle(5);
    chk(exp_q.size() == 0, "R6 drained", OW'(exp_q.size()), '0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule